// File: doc/BRIEF.md
# Bit-Granular Address Stepper

The stepper moves a pointer that addresses single bits in memory. The pointer has three fields: a bit index inside a 16-bit word, a 16-bit page-and-word address, and an 8-bit upper segment. A caller supplies the three fields, a signed 16-bit displacement counted in bits, and a caller tag. The block returns the moved pointer and also reports whether the segment had to change, and in which direction.

The bit index is added first. Its carry feeds the word address, which moves by the displacement divided by sixteen. The word add's carry or borrow then goes into the segment. The source and destination pointers of a copy engine take turns on one stepper. The returned tag shows which pointer set the result belongs to. A run takes two cycles, one more for a negative displacement, and one more when the segment must be fixed.

Top module: `bit_addr_stepper`

## Requirements
- R1: A start is taken only while `busy_o` is low. `busy_o` is high from the edge that takes the start to the edge that raises `done_o`. A start or changed inputs seen while busy have no effect on the run in flight.
- R2: `bit_idx_o` is the low 4 bits of `bit_idx_i + inc_i[3:0]`. A carry out of that 4-bit sum adds 1 to the word address.
- R3: The word step is `inc_i` shifted right by 4, arithmetically, so ones fill the top 4 bits when `inc_i[15]` is 1. `word_addr_o` is `word_addr_i` plus that step plus the nibble carry, modulo 2^16.
- R4: When `inc_i[15]` is 0, a carry out of the 16-bit word add gives `seg_o = seg_i + 1` (mod 256), `seg_mod_o = 2'b01` and `seg_fix_o = 1`. With no carry, `seg_o = seg_i`, `seg_mod_o = 2'b00` and `seg_fix_o = 0`.
- R5: When `inc_i[15]` is 1, no carry out of the word add gives `seg_o = seg_i - 1` (mod 256), `seg_mod_o = 2'b11` and `seg_fix_o = 1`. A carry gives `seg_o = seg_i`, `seg_mod_o = 2'b00` and `seg_fix_o = 0`.
- R6: `done_o` rises 2 clock edges after the edge that takes the start. Add 1 edge when `inc_i[15]` is 1, and 1 more when `seg_fix_o` is set. `done_o` is high for exactly one cycle.
- R7: After reset all outputs are 0. The result outputs change only at the edge that raises `done_o`, and they hold until the next run ends.
- R8: `tag_o` returns the `tag_i` value taken with the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a run when idle |
| tag_i | input | 1 | Caller tag (source or destination set) |
| bit_idx_i | input | 4 | Current bit index |
| word_addr_i | input | 16 | Current page-and-word address |
| seg_i | input | 8 | Current upper segment |
| inc_i | input | 16 | Signed displacement in bits |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle result strobe |
| tag_o | output | 1 | Tag of the finished run |
| bit_idx_o | output | 4 | New bit index |
| word_addr_o | output | 16 | New page-and-word address |
| seg_o | output | 8 | New upper segment |
| seg_mod_o | output | 2 | Segment change: 00 none, 01 up, 11 down |
| seg_fix_o | output | 1 | The segment changed |

## Verification
Each of the 16 starting bit indices is stepped by a set of displacements. The set holds zero, small and large positive steps, small and large negative steps, and the extremes 0x7FFF and 0x8000. The runs start at word addresses 0x0000, 0x0001, 0x8000, 0xFFFE and 0xFFFF, so both a carry and a borrow into the segment occur. Segment values 0x00 and 0xFF show that the segment wraps at both ends.

The expected result treats the pointer as one 28-bit number and adds the sign-extended displacement. This keeps a fault in the nibble carry apart from one in the sign fill or in the carry and borrow sense. The measured latency keeps the negative-step cycle apart from the fix-up cycle. Further runs drive changed inputs while busy and check that the outputs hold while idle.

// File: rtl/stepper_pkg.sv
package stepper_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_BIT, ST_SGN, ST_WORD, ST_FIX
  } step_state_e;

  localparam logic [1:0] SEG_MOD_NONE = 2'b00;
  localparam logic [1:0] SEG_MOD_UP   = 2'b01;
  localparam logic [1:0] SEG_MOD_DOWN = 2'b11;
endpackage

// File: rtl/step_nib_add.sv
module step_nib_add #(
  parameter int BIT_W = 4
) (
  input  logic [BIT_W-1:0] a_i,
  input  logic [BIT_W-1:0] b_i,
  output logic [BIT_W-1:0] sum_o,
  output logic             cy_o
);
  always_comb {cy_o, sum_o} = {1'b0, a_i} + {1'b0, b_i};
endmodule

// File: rtl/step_word_disp.sv
module step_word_disp #(
  parameter int BIT_W  = 4,
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-BIT_W-1:0] inc_hi_i,
  output logic [ADDR_W-1:0]       disp_o
);
  localparam int LO_W = ADDR_W - BIT_W;
  // The top bits start at zero; the sign stage fills them later.
  for (genvar g = 0; g < ADDR_W; g++) begin : g_bit
    if (g < LO_W) begin : g_lo
      assign disp_o[g] = inc_hi_i[g];
    end else begin : g_hi
      assign disp_o[g] = 1'b0;
    end
  end
endmodule

// File: rtl/step_word_add.sv
module step_word_add #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] a_i,
  input  logic [ADDR_W-1:0] b_i,
  input  logic              cin_i,
  output logic [ADDR_W-1:0] sum_o,
  output logic              cout_o
);
  always_comb {cout_o, sum_o} = {1'b0, a_i} + {1'b0, b_i} + {{ADDR_W{1'b0}}, cin_i};
endmodule

// File: rtl/step_seg_adj.sv
module step_seg_adj #(
  parameter int SEG_W = 8
) (
  input  logic             word_cy_i,
  input  logic             neg_i,
  input  logic [SEG_W-1:0] seg_i,
  input  logic [1:0]       mod_i,
  output logic [1:0]       mod_o,
  output logic             fix_o,
  output logic [SEG_W-1:0] seg_o
);
  import stepper_pkg::*;

  always_comb begin
    if (!neg_i && word_cy_i)     mod_o = SEG_MOD_UP;
    else if (neg_i && !word_cy_i) mod_o = SEG_MOD_DOWN;
    else                          mod_o = SEG_MOD_NONE;
    fix_o = (mod_o != SEG_MOD_NONE);
  end

  always_comb seg_o = seg_i + {{(SEG_W-2){mod_i[1]}}, mod_i};
endmodule

// File: rtl/bit_addr_stepper.sv
module bit_addr_stepper #(
  parameter int BIT_W  = 4,
  parameter int ADDR_W = 16,
  parameter int SEG_W  = 8,
  parameter int TAG_W  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [BIT_W-1:0]  bit_idx_i,
  input  logic [ADDR_W-1:0] word_addr_i,
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [ADDR_W-1:0] inc_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [BIT_W-1:0]  bit_idx_o,
  output logic [ADDR_W-1:0] word_addr_o,
  output logic [SEG_W-1:0]  seg_o,
  output logic [1:0]        seg_mod_o,
  output logic              seg_fix_o
);
  import stepper_pkg::*;

  localparam int LO_W = ADDR_W - BIT_W;
  localparam logic [ADDR_W-1:0] FILL_MASK = {{BIT_W{1'b1}}, {LO_W{1'b0}}};

  step_state_e       state_q;
  logic [TAG_W-1:0]  tag_q;
  logic [BIT_W-1:0]  cbit_q;
  logic [ADDR_W-1:0] cword_q;
  logic [SEG_W-1:0]  cseg_q;
  logic [ADDR_W-1:0] cinc_q;
  logic [BIT_W-1:0]  bit_q;
  logic              nib_cy_q;
  logic [ADDR_W-1:0] disp_q;
  logic [ADDR_W-1:0] word_q;
  logic [1:0]        mod_q;

  logic [BIT_W-1:0]  nib_sum;
  logic              nib_cy;
  logic [ADDR_W-1:0] disp_raw;
  logic [ADDR_W-1:0] word_sum;
  logic              word_cy;
  logic [1:0]        mod_w;
  logic              fix_w;
  logic [SEG_W-1:0]  seg_adj;
  logic              neg;

  assign neg = cinc_q[ADDR_W-1];

  step_nib_add #(.BIT_W(BIT_W)) u_nib (
    .a_i(cbit_q), .b_i(cinc_q[BIT_W-1:0]), .sum_o(nib_sum), .cy_o(nib_cy)
  );

  step_word_disp #(.BIT_W(BIT_W), .ADDR_W(ADDR_W)) u_disp (
    .inc_hi_i(cinc_q[ADDR_W-1:BIT_W]), .disp_o(disp_raw)
  );

  step_word_add #(.ADDR_W(ADDR_W)) u_wadd (
    .a_i(cword_q), .b_i(disp_q), .cin_i(nib_cy_q), .sum_o(word_sum), .cout_o(word_cy)
  );

  step_seg_adj #(.SEG_W(SEG_W)) u_seg (
    .word_cy_i(word_cy), .neg_i(neg), .seg_i(cseg_q), .mod_i(mod_q),
    .mod_o(mod_w), .fix_o(fix_w), .seg_o(seg_adj)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      tag_q       <= '0;
      cbit_q      <= '0;
      cword_q     <= '0;
      cseg_q      <= '0;
      cinc_q      <= '0;
      bit_q       <= '0;
      nib_cy_q    <= 1'b0;
      disp_q      <= '0;
      word_q      <= '0;
      mod_q       <= SEG_MOD_NONE;
      done_o      <= 1'b0;
      tag_o       <= '0;
      bit_idx_o   <= '0;
      word_addr_o <= '0;
      seg_o       <= '0;
      seg_mod_o   <= SEG_MOD_NONE;
      seg_fix_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          tag_q   <= tag_i;
          cbit_q  <= bit_idx_i;
          cword_q <= word_addr_i;
          cseg_q  <= seg_i;
          cinc_q  <= inc_i;
          state_q <= ST_BIT;
        end
        ST_BIT: begin
          bit_q    <= nib_sum;
          nib_cy_q <= nib_cy;
          disp_q   <= disp_raw;
          state_q  <= neg ? ST_SGN : ST_WORD;
        end
        ST_SGN: begin
          disp_q  <= disp_q | FILL_MASK;
          state_q <= ST_WORD;
        end
        ST_WORD: begin
          word_q <= word_sum;
          mod_q  <= mod_w;
          if (fix_w) begin
            state_q <= ST_FIX;
          end else begin
            done_o      <= 1'b1;
            tag_o       <= tag_q;
            bit_idx_o   <= bit_q;
            word_addr_o <= word_sum;
            seg_o       <= cseg_q;
            seg_mod_o   <= SEG_MOD_NONE;
            seg_fix_o   <= 1'b0;
            state_q     <= ST_IDLE;
          end
        end
        ST_FIX: begin
          done_o      <= 1'b1;
          tag_o       <= tag_q;
          bit_idx_o   <= bit_q;
          word_addr_o <= word_q;
          seg_o       <= seg_adj;
          seg_mod_o   <= mod_q;
          seg_fix_o   <= 1'b1;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
endmodule

// File: rtl/bit_addr_stepper_chk.sv
module bit_addr_stepper_chk #(
  parameter int BIT_W  = 4,
  parameter int ADDR_W = 16,
  parameter int SEG_W  = 8,
  parameter int TAG_W  = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [TAG_W-1:0]  tag_i,
  input logic [BIT_W-1:0]  bit_idx_i,
  input logic [SEG_W-1:0]  seg_i,
  input logic [ADDR_W-1:0] inc_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [TAG_W-1:0]  tag_o,
  input logic [BIT_W-1:0]  bit_idx_o,
  input logic [ADDR_W-1:0] word_addr_o,
  input logic [SEG_W-1:0]  seg_o,
  input logic [1:0]        seg_mod_o,
  input logic              seg_fix_o
);
  logic [TAG_W-1:0]  k_tag;
  logic [BIT_W-1:0]  k_bit;
  logic [SEG_W-1:0]  k_seg;
  logic [BIT_W-1:0]  k_inc_lo;
  logic              k_neg;
  logic [2:0]        k_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      k_tag <= '0; k_bit <= '0; k_seg <= '0; k_inc_lo <= '0; k_neg <= 1'b0; k_cnt <= '0;
    end else if (!busy_o && start_i) begin
      k_tag <= tag_i; k_bit <= bit_idx_i; k_seg <= seg_i;
      k_inc_lo <= inc_i[BIT_W-1:0]; k_neg <= inc_i[ADDR_W-1]; k_cnt <= '0;
    end else if (busy_o) begin
      k_cnt <= k_cnt + 3'd1;
    end
  end

  a_r1_start_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);
  a_r1_busy_until_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> (busy_o || done_o));
  a_r2_bit_idx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> bit_idx_o == BIT_W'(k_bit + k_inc_lo));
  a_r4_r5_seg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> seg_o == SEG_W'(k_seg + {{(SEG_W-2){seg_mod_o[1]}}, seg_mod_o}));
  a_r4_r5_dir: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && seg_fix_o) |-> seg_mod_o == (k_neg ? 2'b11 : 2'b01));
  a_r6_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> k_cnt == 3'd2 + {2'b0, k_neg} + {2'b0, seg_fix_o});
  a_r6_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(word_addr_o) && $stable(seg_o) && $stable(bit_idx_o)
                 && $stable(seg_mod_o) && $stable(seg_fix_o) && $stable(tag_o)));
  a_r8_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> tag_o == k_tag);
endmodule

bind bit_addr_stepper bit_addr_stepper_chk #(
  .BIT_W(BIT_W), .ADDR_W(ADDR_W), .SEG_W(SEG_W), .TAG_W(TAG_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .tag_i(tag_i),
  .bit_idx_i(bit_idx_i), .seg_i(seg_i), .inc_i(inc_i),
  .busy_o(busy_o), .done_o(done_o), .tag_o(tag_o), .bit_idx_o(bit_idx_o),
  .word_addr_o(word_addr_o), .seg_o(seg_o), .seg_mod_o(seg_mod_o), .seg_fix_o(seg_fix_o)
);

// File: tb/bit_addr_stepper_tb_top.sv
`timescale 1ns/1ps
module bit_addr_stepper_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        tag_in = 1'b0;
  logic [3:0]  bit_in = '0;
  logic [15:0] word_in = '0;
  logic [7:0]  seg_in = '0;
  logic [15:0] inc_in = '0;
  logic        busy, done, tag_out, fix_out;
  logic [3:0]  bit_out;
  logic [15:0] word_out;
  logic [7:0]  seg_out;
  logic [1:0]  mod_out;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  bit_addr_stepper dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .tag_i(tag_in),
    .bit_idx_i(bit_in), .word_addr_i(word_in), .seg_i(seg_in), .inc_i(inc_in),
    .busy_o(busy), .done_o(done), .tag_o(tag_out), .bit_idx_o(bit_out),
    .word_addr_o(word_out), .seg_o(seg_out), .seg_mod_o(mod_out), .seg_fix_o(fix_out)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // One run; junk=1 drives a different start and inputs while busy (R1).
  task automatic run_op(input logic t, input logic [3:0] b, input logic [15:0] w,
                        input logic [7:0] s, input logic [15:0] inc, input bit junk);
    logic [27:0] p, np;
    logic [7:0]  e_seg;
    logic        e_fix;
    logic [1:0]  e_mod;
    int          e_lat, lat;
    p  = {s, w, b};
    np = p + {{12{inc[15]}}, inc};
    e_seg = np[27:20];
    e_fix = (e_seg != s);
    e_mod = !e_fix ? 2'b00 : (inc[15] ? 2'b11 : 2'b01);
    e_lat = 2 + int'(inc[15]) + int'(e_fix);
    @(negedge clk);
    start = 1'b1; tag_in = t; bit_in = b; word_in = w; seg_in = s; inc_in = inc;
    @(posedge clk);
    @(negedge clk);
    lat = 1;
    if (junk) begin
      tag_in = ~t; bit_in = ~b; word_in = ~w; seg_in = ~s; inc_in = inc ^ 16'h8421;
      chk(busy, "R1 busy after start", busy, 1);
      if (done) lat = 99;
      @(posedge clk);
      @(negedge clk);
      lat = lat + 1;
    end
    start = 1'b0;
    while (!done && lat < 12) begin
      @(posedge clk);
      @(negedge clk);
      if (!done) lat++;
    end
    chk(lat == e_lat, "R6 latency", lat, e_lat);
    chk(bit_out == np[3:0], "R2 bit index", bit_out, np[3:0]);
    chk(word_out == np[19:4], "R3 word address", word_out, np[19:4]);
    chk(seg_out == e_seg, inc[15] ? "R5 segment" : "R4 segment", seg_out, e_seg);
    chk(mod_out == e_mod && fix_out == e_fix, inc[15] ? "R5 modifier" : "R4 modifier",
        {mod_out, fix_out}, {e_mod, e_fix});
    chk(tag_out == t, "R8 tag", tag_out, t);
    chk(!busy, "R1 idle at done", busy, 0);
    @(posedge clk);
    @(negedge clk);
    chk(!done, "R6 single pulse", done, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      summary();
    end
  end

  initial begin : main
    logic [15:0] incs [12];
    logic [15:0] addrs [5];
    logic [7:0]  segs [2];
    incs = '{16'h0000, 16'h0001, 16'h000F, 16'h0010, 16'h0123, 16'h7FFF,
             16'hFFFF, 16'hFFF1, 16'hFFF0, 16'hFEDC, 16'h8000, 16'h8001};
    addrs = '{16'h0000, 16'h0001, 16'h8000, 16'hFFFE, 16'hFFFF};
    segs = '{8'h00, 8'hFF};
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !done && bit_out == 0 && word_out == 0 && seg_out == 0 &&
        mod_out == 0 && !fix_out && !tag_out, "R7 reset state",
        {busy, done, word_out}, 0);
    rst_n = 1'b1;
    for (int si = 0; si < 2; si++)
      for (int ai = 0; ai < 5; ai++)
        for (int ii = 0; ii < 12; ii++)
          for (int b = 0; b < 16; b++)
            run_op(1'((b + ii) & 1), 4'(b), addrs[ai], segs[si], incs[ii], 1'b0);
    // R1: changed inputs while busy, both signs and both fix paths
    run_op(1'b1, 4'hF, 16'hFFFF, 8'h12, 16'h0001, 1'b1);
    run_op(1'b0, 4'h0, 16'h0000, 8'h12, 16'hFFFF, 1'b1);
    run_op(1'b1, 4'h3, 16'h1234, 8'h80, 16'h0040, 1'b1);
    // R7: outputs hold while idle and while a start is pending off
    begin
      logic [15:0] w0;
      logic [7:0]  s0;
      w0 = word_out; s0 = seg_out;
      repeat (5) @(negedge clk);
      chk(word_out == w0 && seg_out == s0, "R7 hold while idle", {word_out, seg_out}, {w0, s0});
    end
    finished = 1'b1;
    summary();
  end
endmodule